// File: doc/BRIEF.md
# Per-Word Fuse Lock Bank

This block keeps the lock state that a fuse controller consults before it acts on a word. Each fuse word owns one bit in each of three software-set lock bitmaps: one stops a shadow reload from the fuse array, one stops bus writes into the word's shadow data, and one stops programming the word. A fourth, read-only bitmap shows the locks already burned into the fuses, and is supplied by the fuse array on an input bus. Every bitmap is split into 32-bit banks. Word `w` lives in bank `w >> 5` at bit `w & 31`.

Software sets locks by writing a mask into a bank register. Every 1 in the mask sets a lock, and a set lock stays set until reset. The fuse controller presents a word index and receives three deny signals, one for each kind of operation, within the same cycle. Two chip-wide inputs take part in gating. One marks the device state as invalid, which refuses every lock write. The other freezes all programming.

Top module: `fuse_lock_bank`

## Requirements
- R1: After a synchronous active-low reset, every software lock bit reads 0. A reset asserted later clears locks that were set before it.
- R2: The register banks sit at byte addresses base + 4*k for k = 0, 1, 2. The program-lock base is 0x064, the shadow-write-lock base is 0x07C and the reload-lock base is 0x094. Bank k bit b belongs to word 32*k + b.
- R3: A write ORs its data into the addressed bank. Zero data bits leave stored bits unchanged. A written value reads back from the edge after the write onward.
- R4: A read of 0x04C + 4*k returns bits 32*k+31 down to 32*k of `perm_lock_i`.
- R5: While `invalid_i` is 1, a write to any lock region changes no lock bit, and `wr_err_o` is 1 in the cycle after the write.
- R6: A write to the permanent region 0x04C..0x063, or to slots 3..5 of a software region (for example 0x070), changes nothing and raises `wr_err_o` for exactly one cycle after it. A write outside 0x04C..0x0AB is ignored with no error.
- R7: `reload_deny_o` is 1 exactly when the reload lock of word `op_word_i` is set, or when the index is out of range.
- R8: `shwr_deny_o` is 1 exactly when the shadow-write lock of word `op_word_i` is set, or when the index is out of range.
- R9: `prog_deny_o` is 1 when the program lock or the permanent lock of word `op_word_i` is set.
- R10: While `prog_freeze_i` is 1, `prog_deny_o` is 1 for every word. The other two deny outputs are not affected.
- R11: An `op_word_i` of 96 or more raises all three deny outputs.
- R12: A read of an unmapped address, including slots 3..5 of a region, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Mask of lock bits to set |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| invalid_i | input | 1 | Device state invalid, all lock writes refused |
| prog_freeze_i | input | 1 | Chip-wide block on all programming |
| perm_lock_i | input | 96 | Permanent lock bits read from the fuses |
| op_word_i | input | 7 | Word index of the pending fuse operation |
| reload_deny_o | output | 1 | Shadow reload of the word is refused |
| shwr_deny_o | output | 1 | Bus write to the word's shadow is refused |
| prog_deny_o | output | 1 | Programming of the word is refused |
| wr_err_o | output | 1 | One-cycle pulse after a refused write |

## Verification
The assertions assume that `wr_en` is a single-cycle strobe and that `wr_addr` and `wr_data` are stable while it is high. They also assume that `invalid_i` and `prog_freeze_i` change only between writes. The stickiness and hold checks compare each bitmap against its value one edge earlier, and they only apply once the previous edge was outside reset. The bench keeps within these assumptions: it changes every input on the falling edge and raises `wr_en` for one cycle per write task. It also samples results one cycle after the write, where the registered error pulse and the updated bitmaps appear.

// File: rtl/flk_pkg.sv
// Package: shared definitions for the fuse lock bank.
// Assumes: region kinds are mutually exclusive and decoded from the byte address.
package flk_pkg;
    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_PERM   = 3'd1,
        KIND_PROG   = 3'd2,
        KIND_SHWR   = 3'd3,
        KIND_RELOAD = 3'd4
    } lock_kind_e;

    // Number of software lock kinds held in bitmaps
    localparam int SOFT_KINDS = 3;
endpackage

// File: rtl/flk_decode.sv
// Module: flk_decode
// Maps a byte address onto a lock region and a register slot in it.
// Assumes: regions do not overlap; each spans SLOTS word-aligned registers.
module flk_decode
    import flk_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SLOTS     = 6,
    parameter int NUM_BANKS = 3,
    parameter logic [ADDR_W-1:0] PERM_BASE = 12'h04C,
    parameter logic [ADDR_W-1:0] PROG_BASE = 12'h064,
    parameter logic [ADDR_W-1:0] SHWR_BASE = 12'h07C,
    parameter logic [ADDR_W-1:0] RLD_BASE  = 12'h094,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [ADDR_W-1:0] addr,
    output lock_kind_e        kind,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_ok
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * SLOTS);

    // True when addr is a word-aligned register inside the region at base
    function automatic logic in_region(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] off;
        off = a - base;
        return (a >= base) && (off < SPAN) && (a[1:0] == 2'b00);
    endfunction

    // Slot index of addr relative to base
    function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] off;
        off = a - base;
        return off[2 +: SLOT_W];
    endfunction

    // Region and slot selection
    always_comb begin
        kind = KIND_NONE;
        slot = '0;
        if (in_region(addr, PERM_BASE)) begin
            kind = KIND_PERM;
            slot = slot_of(addr, PERM_BASE);
        end else if (in_region(addr, PROG_BASE)) begin
            kind = KIND_PROG;
            slot = slot_of(addr, PROG_BASE);
        end else if (in_region(addr, SHWR_BASE)) begin
            kind = KIND_SHWR;
            slot = slot_of(addr, SHWR_BASE);
        end else if (in_region(addr, RLD_BASE)) begin
            kind = KIND_RELOAD;
            slot = slot_of(addr, RLD_BASE);
        end
    end

    // A slot is backed by a register only below the bank count
    assign slot_ok = (kind != KIND_NONE) && (32'(slot) < NUM_BANKS);
endmodule

// File: rtl/flk_bitmap.sv
// Module: flk_bitmap
// One sticky lock bitmap: a write ORs a mask into one bank, and only reset clears it.
// Assumes: set_en is already qualified by decode, state and bank range.
module flk_bitmap #(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    localparam int NUM_WORDS = NUM_BANKS * DATA_W,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [BANK_W-1:0]    bank,
    input  logic [DATA_W-1:0]    mask,
    output logic [NUM_WORDS-1:0] bits
);
    // One register per bank, set-only
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[g*DATA_W +: DATA_W] <= '0;
            else if (set_en && (32'(bank) == g))
                bits[g*DATA_W +: DATA_W] <= bits[g*DATA_W +: DATA_W] | mask;
        end
    end

    // R3
    sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((bits & $past(bits)) == $past(bits)));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(set_en)) |-> (bits == $past(bits)));
endmodule

// File: rtl/flk_gate.sv
// Module: flk_gate
// Looks up the locks of one word and forms the per-operation deny signals.
// Assumes: word indices at or above NUM_WORDS address no fuse and are refused.
module flk_gate #(
    parameter int NUM_WORDS = 96,
    localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic [WIDX_W-1:0]    word,
    input  logic [NUM_WORDS-1:0] prog_bits,
    input  logic [NUM_WORDS-1:0] shwr_bits,
    input  logic [NUM_WORDS-1:0] rld_bits,
    input  logic [NUM_WORDS-1:0] perm_bits,
    input  logic                 freeze,
    output logic                 reload_deny,
    output logic                 shwr_deny,
    output logic                 prog_deny
);
    logic in_range;

    // Range check on the word index
    assign in_range = 32'(word) < NUM_WORDS;

    // Per-operation refusal
    always_comb begin
        reload_deny = 1'b1;
        shwr_deny   = 1'b1;
        prog_deny   = 1'b1;
        if (in_range) begin
            reload_deny = rld_bits[word];
            shwr_deny   = shwr_bits[word];
            prog_deny   = prog_bits[word] | perm_bits[word] | freeze;
        end
    end
endmodule

// File: rtl/fuse_lock_bank.sv
// Module: fuse_lock_bank (top)
// Holds program, shadow-write and reload lock bitmaps, mirrors permanent locks,
// serves register reads and writes, and gates fuse operations per word.
// Assumes: wr_en is a one-cycle strobe; the read path is combinational.
module fuse_lock_bank
    import flk_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 3,
    parameter int SLOTS     = 6,
    parameter logic [ADDR_W-1:0] PERM_BASE = 12'h04C,
    parameter logic [ADDR_W-1:0] PROG_BASE = 12'h064,
    parameter logic [ADDR_W-1:0] SHWR_BASE = 12'h07C,
    parameter logic [ADDR_W-1:0] RLD_BASE  = 12'h094,
    localparam int NUM_WORDS = NUM_BANKS * DATA_W,
    localparam int WIDX_W    = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 invalid_i,
    input  logic                 prog_freeze_i,
    input  logic [NUM_WORDS-1:0] perm_lock_i,
    input  logic [WIDX_W-1:0]    op_word_i,
    output logic                 reload_deny_o,
    output logic                 shwr_deny_o,
    output logic                 prog_deny_o,
    output logic                 wr_err_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    lock_kind_e        w_kind, r_kind;
    logic [SLOT_W-1:0] w_slot, r_slot;
    logic              w_ok, r_ok;
    logic              w_refused;
    logic [NUM_WORDS-1:0] soft_bits [SOFT_KINDS];

    flk_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .NUM_BANKS(NUM_BANKS),
                 .PERM_BASE(PERM_BASE), .PROG_BASE(PROG_BASE),
                 .SHWR_BASE(SHWR_BASE), .RLD_BASE(RLD_BASE))
        u_wdec (.addr(wr_addr), .kind(w_kind), .slot(w_slot), .slot_ok(w_ok));

    flk_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .NUM_BANKS(NUM_BANKS),
                 .PERM_BASE(PERM_BASE), .PROG_BASE(PROG_BASE),
                 .SHWR_BASE(SHWR_BASE), .RLD_BASE(RLD_BASE))
        u_rdec (.addr(rd_addr), .kind(r_kind), .slot(r_slot), .slot_ok(r_ok));

    // One sticky bitmap per software lock kind; index 0 program, 1 shadow-write, 2 reload
    for (genvar k = 0; k < SOFT_KINDS; k++) begin : g_kind
        localparam lock_kind_e MY_KIND = lock_kind_e'(int'(KIND_PROG) + k);
        logic set_en;

        // Accepted write to this kind's bank
        assign set_en = wr_en && !invalid_i && w_ok && (w_kind == MY_KIND);

        flk_bitmap #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_map (
            .clk(clk), .rst_n(rst_n), .set_en(set_en),
            .bank(w_slot[BANK_W-1:0]), .mask(wr_data), .bits(soft_bits[k]));
    end

    // Refused writes: any lock-region write while invalid, permanent region, missing slot
    assign w_refused = wr_en && (w_kind != KIND_NONE) &&
                       (invalid_i || (w_kind == KIND_PERM) || !w_ok);

    // Registered one-cycle error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err_o <= 1'b0;
        else        wr_err_o <= w_refused;
    end

    // Read mux over the four bitmaps
    always_comb begin
        int base_bit;
        base_bit = r_ok ? int'(r_slot) * DATA_W : 0;
        rd_data  = '0;
        if (r_ok) begin
            case (r_kind)
                KIND_PERM:   rd_data = perm_lock_i[base_bit +: DATA_W];
                KIND_PROG:   rd_data = soft_bits[0][base_bit +: DATA_W];
                KIND_SHWR:   rd_data = soft_bits[1][base_bit +: DATA_W];
                KIND_RELOAD: rd_data = soft_bits[2][base_bit +: DATA_W];
                default:     rd_data = '0;
            endcase
        end
    end

    flk_gate #(.NUM_WORDS(NUM_WORDS)) u_gate (
        .word(op_word_i), .prog_bits(soft_bits[0]), .shwr_bits(soft_bits[1]),
        .rld_bits(soft_bits[2]), .perm_bits(perm_lock_i), .freeze(prog_freeze_i),
        .reload_deny(reload_deny_o), .shwr_deny(shwr_deny_o), .prog_deny(prog_deny_o));

    // R6
    err_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |-> $past(wr_en));

    // R5
    invalid_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(invalid_i)) |->
        (soft_bits[0] == $past(soft_bits[0]) && soft_bits[1] == $past(soft_bits[1]) &&
         soft_bits[2] == $past(soft_bits[2])));

    // R10
    freeze_denies_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_freeze_i |-> prog_deny_o);

    // R9
    perm_denies_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(op_word_i) < NUM_WORDS && perm_lock_i[op_word_i]) |-> prog_deny_o);

    // R12
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_ok |-> (rd_data == '0));
endmodule

// File: tb/sim_fuse_lock_bank.sv
module sim_fuse_lock_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        invalid_i = 1'b0;
    logic        prog_freeze_i = 1'b0;
    logic [95:0] perm_lock_i = '0;
    logic [6:0]  op_word_i = '0;
    logic        reload_deny_o, shwr_deny_o, prog_deny_o, wr_err_o;

    int checks = 0;
    int errors = 0;

    fuse_lock_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .invalid_i(invalid_i),
        .prog_freeze_i(prog_freeze_i), .perm_lock_i(perm_lock_i), .op_word_i(op_word_i),
        .reload_deny_o(reload_deny_o), .shwr_deny_o(shwr_deny_o),
        .prog_deny_o(prog_deny_o), .wr_err_o(wr_err_o));

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One-cycle write; returns the error pulse seen one cycle later
    task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1 err = wr_err_o;
    endtask

    task automatic read_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic probe(input logic [6:0] w);
        @(negedge clk);
        op_word_i = w;
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        for (int k = 0; k < 3; k++) begin
            read_reg(12'h064 + 12'(4*k), d); check("R1 prog reset", d, 0);
            read_reg(12'h07C + 12'(4*k), d); check("R1 shwr reset", d, 0);
            read_reg(12'h094 + 12'(4*k), d); check("R1 reload reset", d, 0);
        end
        check("R1 err idle", 32'(wr_err_o), 0);
    endtask

    task automatic t_set_sticky();
        logic e; logic [31:0] d;
        do_write(12'h064, 32'h5, e); check("R3 no err", 32'(e), 0);
        read_reg(12'h064, d); check("R2 R3 prog bank0", d, 32'h5);
        do_write(12'h064, 32'h0, e);
        read_reg(12'h064, d); check("R3 zero write keeps", d, 32'h5);
        do_write(12'h064, 32'h2, e);
        read_reg(12'h064, d); check("R3 OR in", d, 32'h7);
        do_write(12'h084, 32'h8000_0000, e);
        read_reg(12'h084, d); check("R2 shwr bank2", d, 32'h8000_0000);
        read_reg(12'h080, d); check("R2 shwr bank1 untouched", d, 0);
    endtask

    task automatic t_gating();
        logic e;
        probe(7'd95);
        check("R8 word95 shwr", 32'(shwr_deny_o), 1);
        check("R7 word95 reload", 32'(reload_deny_o), 0);
        do_write(12'h098, 32'h8, e);
        probe(7'd35); check("R7 word35 reload", 32'(reload_deny_o), 1);
        check("R8 word35 shwr", 32'(shwr_deny_o), 0);
        probe(7'd34); check("R7 word34 reload", 32'(reload_deny_o), 0);
        probe(7'd0);  check("R9 word0 prog", 32'(prog_deny_o), 1);
        probe(7'd3);  check("R9 word3 free", 32'(prog_deny_o), 0);
    endtask

    task automatic t_perm();
        logic [31:0] d;
        @(negedge clk);
        perm_lock_i = {32'hCAFE_0001, 32'h1234_5678, 32'h0000_0008};
        read_reg(12'h04C, d); check("R4 perm bank0", d, 32'h0000_0008);
        read_reg(12'h050, d); check("R4 perm bank1", d, 32'h1234_5678);
        read_reg(12'h054, d); check("R4 perm bank2", d, 32'hCAFE_0001);
        probe(7'd3); check("R9 perm word3", 32'(prog_deny_o), 1);
        check("R9 perm no reload", 32'(reload_deny_o), 0);
    endtask

    task automatic t_invalid();
        logic e; logic [31:0] d;
        @(negedge clk); invalid_i = 1'b1;
        do_write(12'h068, 32'h0000_FFFF, e); check("R5 err pulse", 32'(e), 1);
        read_reg(12'h068, d); check("R5 no lock set", d, 0);
        @(negedge clk); invalid_i = 1'b0;
    endtask

    task automatic t_bad_writes();
        logic e; logic [31:0] d;
        do_write(12'h070, 32'hFFFF_FFFF, e); check("R6 slot3 err", 32'(e), 1);
        @(negedge clk); #1 check("R6 one cycle", 32'(wr_err_o), 0);
        read_reg(12'h070, d); check("R12 slot3 reads 0", d, 0);
        read_reg(12'h064, d); check("R6 prog bank0 kept", d, 32'h7);
        do_write(12'h050, 32'hFFFF_FFFF, e); check("R6 perm err", 32'(e), 1);
        read_reg(12'h050, d); check("R6 perm unchanged", d, 32'h1234_5678);
        do_write(12'h200, 32'hFFFF_FFFF, e); check("R6 outside no err", 32'(e), 0);
        read_reg(12'h200, d); check("R12 unmapped 0", d, 0);
    endtask

    task automatic t_freeze_range();
        probe(7'd40);
        check("R10 baseline", 32'(prog_deny_o), 0);
        @(negedge clk); prog_freeze_i = 1'b1; #1;
        check("R10 freeze prog", 32'(prog_deny_o), 1);
        check("R10 reload unaffected", 32'(reload_deny_o), 0);
        @(negedge clk); prog_freeze_i = 1'b0;
        probe(7'd100);
        check("R11 oor reload", 32'(reload_deny_o), 1);
        check("R11 oor shwr", 32'(shwr_deny_o), 1);
        check("R11 oor prog", 32'(prog_deny_o), 1);
    endtask

    task automatic t_reset_clears();
        logic [31:0] d;
        apply_reset();
        read_reg(12'h064, d); check("R1 reset clears prog", d, 0);
        read_reg(12'h098, d); check("R1 reset clears reload", d, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        apply_reset();
        t_reset_state();
        t_set_sticky();
        t_gating();
        t_perm();
        t_invalid();
        t_bad_writes();
        t_freeze_range();
        t_reset_clears();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule